// File: doc/BRIEF.md
# Gated HDLC Transmit Framer

This block turns host messages into a continuous HDLC bit stream. The host loads message bytes into a 64-entry transmit buffer and marks the final byte of each message. The framer wraps every message in flags, applies zero insertion and appends a 16-bit frame check sequence. When no message is waiting, it fills the line with idle flags.

The serial output advances only on cycles where the `gate` input is high. Logic outside this block drives `gate` from the line's frame timing. It raises `gate` either in the selected spare-bit positions or in the bit times of the chosen full or partial 64 kbit/s channels. On cycles with `gate` low the framer holds all of its state.

A host request, or a buffer that runs dry in the middle of a message, makes the framer send an abort sequence and discard what is buffered. A buffer underrun also raises a status output. That output stays high until the next frame begins.

Top module: `hdlc_gated_tx`

## Requirements
- R1: While reset is held, and after it is released, `tx_bit` is 1, `underrun` is 0 and `buf_ready` is 1. The first gated bits after reset form a flag.
- R2: With an empty buffer, the gated bits are back-to-back flags. A flag is the octet 0x7E sent least significant bit first, giving the time order 0,1,1,1,1,1,1,0.
- R3: On a clock edge with `gate` low, `tx_bit` and all framer state stay unchanged. Each edge with `gate` high presents exactly one new line bit on `tx_bit`.
- R4: A message is sent as the flag that precedes it, then its bytes in write order, each least significant bit first. The final byte is the one written with `wr_eom` = 1.
- R5: Inside a frame, covering data and check sequence, a 0 is inserted after every run of five 1s. As a result, no six consecutive 1s appear between the opening and closing flags.
- R6: The check sequence uses the CRC-16 polynomial x^16+x^12+x^5+1 with the register preset to 0xFFFF, fed data bits in line order. It is sent one's-complemented, least significant bit first, right after the final byte, and is followed by a closing flag.
- R7: The buffer holds 64 bytes. `buf_ready` is 0 while 64 bytes are stored, and a write in that state is ignored.
- R8: A pulse on `abort_req` makes the framer send eight consecutive 1s once the unit in progress completes. Flags then follow, and every byte in the buffer is discarded.
- R9: If the buffer is empty after a byte that carries no end-of-message mark, the framer sends the abort sequence and sets `underrun`. The flag clears when the next frame starts.
- R10: Messages queued together go out with a single flag between them, and each one is decoded intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write one byte into the transmit buffer |
| wr_byte | input | 8 | Message byte |
| wr_eom | input | 1 | Marks the written byte as the last of its message |
| buf_ready | output | 1 | Buffer has room for a byte |
| gate | input | 1 | High in bit slots assigned to this channel |
| abort_req | input | 1 | One-cycle request to abort the frame in progress |
| tx_bit | output | 1 | Serial line bit, valid after each gated edge |
| underrun | output | 1 | Buffer ran dry inside a message |

## Verification
The assertions treat `gate` as a free level with no pattern of its own, and treat `abort_req` as allowed on any cycle. They assume the host never writes to the buffer on the same edge that an abort empties it. The bench keeps to that rule by writing messages only while `gate` is low, so the framer is frozen during writes and no boundary can fall on a write. For the same reason, an underrun happens only when the bench holds back the end-of-message mark on purpose. The bench decodes the captured line bits with its own receiver: it finds flags, removes stuffed zeros, spots aborts and checks the CRC residue. Gated cycles are spread at random, so the holding behaviour is exercised throughout.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  // Kind of line unit being shifted out
  typedef enum logic [1:0] {
    UNIT_FLAG  = 2'd0,
    UNIT_DATA  = 2'd1,
    UNIT_FCS   = 2'd2,
    UNIT_ABORT = 2'd3
  } unit_e;

  localparam logic [7:0]  FLAG_OCTET   = 8'h7E;
  localparam logic [7:0]  ABORT_OCTET  = 8'hFF;
  localparam logic [15:0] FCS_PRESET   = 16'hFFFF;
  localparam logic [15:0] FCS_POLY_LSB = 16'h8408;
  localparam int unsigned STUFF_RUN    = 5;
  localparam int unsigned OCTET_BITS   = 8;
  localparam int unsigned FCS_BITS     = 16;

  // One bit of the LSB-first CRC-16 update
  function automatic logic [15:0] fcs_step(input logic [15:0] acc, input logic b);
    logic fb;
    fb = acc[0] ^ b;
    fcs_step = (acc >> 1) ^ (fb ? FCS_POLY_LSB : 16'h0000);
  endfunction

endpackage

// File: rtl/hdlc_tx_buf.sv
module hdlc_tx_buf #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  input  logic             flush,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    rd_ptr, wr_ptr;
  logic [CW-1:0]    count;
  logic             push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    ptr_inc = (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full); // R7
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) count <= CW'(DEPTH)); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) flush |=> empty); // R8

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gate,
  input  logic       abort_req,
  input  logic [7:0] head_byte,
  input  logic       head_eom,
  input  logic       buf_empty,
  output logic       pop,
  output logic       flush,
  output logic       tx_bit,
  output logic       underrun
);
  localparam int LW = $clog2(FCS_BITS + 1);

  unit_e         kind, nxt_kind;
  logic [15:0]   sh, sh_n, nxt_sh;
  logic [LW-1:0] left, left_n, nxt_left;
  logic [2:0]    ones, ones_n;
  logic [15:0]   crc, crc_n;
  logic          cur_eom, abort_pend, tx_q, underrun_q;

  // named internal events
  logic stuff_en, do_stuff, emit_bit, unit_done;
  logic frame_start, underrun_evt, abort_take;

  always_comb begin
    stuff_en = (kind == UNIT_DATA) || (kind == UNIT_FCS);
    do_stuff = stuff_en && (ones == 3'(STUFF_RUN));
    emit_bit = do_stuff ? 1'b0 : sh[0];
    left_n   = do_stuff ? left : left - LW'(1);
    sh_n     = do_stuff ? sh : {1'b0, sh[15:1]};
    ones_n   = (!stuff_en || do_stuff || !sh[0]) ? 3'd0 : ones + 3'd1;
    crc_n    = (kind == UNIT_DATA && !do_stuff) ? fcs_step(crc, sh[0]) : crc;
    // a unit ends only once any zero owed after its last bit is out
    unit_done = (left_n == '0) && !(stuff_en && ones_n == 3'(STUFF_RUN));

    frame_start  = 1'b0;
    underrun_evt = 1'b0;
    abort_take   = 1'b0;
    if (unit_done) begin
      if (abort_pend) abort_take = 1'b1;
      else if (kind == UNIT_FLAG && !buf_empty) frame_start = 1'b1;
      else if (kind == UNIT_DATA && !cur_eom && buf_empty) underrun_evt = 1'b1;
    end

    if (abort_take || underrun_evt) nxt_kind = UNIT_ABORT;
    else begin
      unique case (kind)
        UNIT_FLAG: nxt_kind = frame_start ? UNIT_DATA : UNIT_FLAG;
        UNIT_DATA: nxt_kind = cur_eom ? UNIT_FCS : UNIT_DATA;
        default:   nxt_kind = UNIT_FLAG;
      endcase
    end

    unique case (nxt_kind)
      UNIT_DATA:  begin nxt_sh = {8'h00, head_byte};   nxt_left = LW'(OCTET_BITS); end
      UNIT_FCS:   begin nxt_sh = ~crc_n;               nxt_left = LW'(FCS_BITS);   end
      UNIT_ABORT: begin nxt_sh = {8'h00, ABORT_OCTET}; nxt_left = LW'(OCTET_BITS); end
      default:    begin nxt_sh = {8'h00, FLAG_OCTET};  nxt_left = LW'(OCTET_BITS); end
    endcase
  end

  assign pop      = gate && unit_done && (nxt_kind == UNIT_DATA);
  assign flush    = gate && unit_done && (nxt_kind == UNIT_ABORT);
  assign tx_bit   = tx_q;
  assign underrun = underrun_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind       <= UNIT_FLAG;
      sh         <= {8'h00, FLAG_OCTET};
      left       <= LW'(OCTET_BITS);
      ones       <= '0;
      crc        <= FCS_PRESET;
      cur_eom    <= 1'b0;
      abort_pend <= 1'b0;
      tx_q       <= 1'b1;
      underrun_q <= 1'b0;
    end else begin
      abort_pend <= (abort_pend && !(gate && abort_take)) || abort_req;
      if (gate) begin
        tx_q <= emit_bit;
        ones <= ones_n;
        crc  <= frame_start ? FCS_PRESET : crc_n;
        if (unit_done) begin
          kind <= nxt_kind;
          sh   <= nxt_sh;
          left <= nxt_left;
          if (nxt_kind == UNIT_DATA) cur_eom <= head_eom;
        end else begin
          sh   <= sh_n;
          left <= left_n;
        end
        if (underrun_evt)     underrun_q <= 1'b1;
        else if (frame_start) underrun_q <= 1'b0;
      end
    end
  end

  // independent run counter of emitted ones inside frames
  logic [2:0] seen_ones;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_ones <= '0;
    else if (gate) seen_ones <= (stuff_en && emit_bit) ? ((seen_ones == 3'd7) ? 3'd7 : seen_ones + 3'd1) : 3'd0;
  end

  AST_HOLD_OFF_GATE: assert property (@(posedge clk) disable iff (!rst_n) !gate |=> $stable(tx_bit)); // R3
  AST_NO_SIX_ONES: assert property (@(posedge clk) disable iff (!rst_n) seen_ones <= 3'(STUFF_RUN)); // R5
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !buf_empty); // R7
  AST_FCS_AFTER_EOM: assert property (@(posedge clk) disable iff (!rst_n)
    gate && unit_done && kind == UNIT_DATA && cur_eom && !abort_pend |=> kind == UNIT_FCS); // R6
  AST_UNDERRUN_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    gate && underrun_evt |=> kind == UNIT_ABORT && underrun); // R9

endmodule

// File: rtl/hdlc_gated_tx.sv
module hdlc_gated_tx #(
  parameter int BUF_DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic [7:0] wr_byte,
  input  logic       wr_eom,
  output logic       buf_ready,
  input  logic       gate,
  input  logic       abort_req,
  output logic       tx_bit,
  output logic       underrun
);
  localparam int ENTRY_W = 9;

  logic [ENTRY_W-1:0] head;
  logic buf_empty, buf_full, push, pop, flush;

  assign buf_ready = !buf_full;
  assign push      = wr_valid && !buf_full;

  hdlc_tx_buf #(.DEPTH(BUF_DEPTH), .WIDTH(ENTRY_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data({wr_eom, wr_byte}),
    .pop(pop), .flush(flush), .head(head), .empty(buf_empty), .full(buf_full)
  );

  hdlc_tx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .gate(gate), .abort_req(abort_req),
    .head_byte(head[7:0]), .head_eom(head[8]), .buf_empty(buf_empty),
    .pop(pop), .flush(flush), .tx_bit(tx_bit), .underrun(underrun)
  );

endmodule

// File: tb/test_hdlc_gated_tx.sv
`timescale 1ns/1ps
module test_hdlc_gated_tx;
  logic clk = 1'b0;
  logic rst_n, wr_valid, wr_eom, gate, abort_req;
  logic [7:0] wr_byte;
  wire  buf_ready, tx_bit, underrun;

  always #5 clk = ~clk;

  hdlc_gated_tx i_hdlc_gated_tx (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_byte(wr_byte), .wr_eom(wr_eom),
    .buf_ready(buf_ready), .gate(gate), .abort_req(abort_req), .tx_bit(tx_bit), .underrun(underrun)
  );

  int checks = 0, errors = 0, hold_err = 0;
  bit sq[$];
  logic last_tx = 1'b1;
  // receiver state
  int d_ones = 0, abort_cnt = 0, stuff_cnt = 0;
  bit d_in = 1'b0;
  bit cur[$];
  logic [7:0] rx_bytes[$], exp_bytes[$];
  int rx_lens[$], exp_lens[$];
  bit rx_crcok[$];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_msb(input logic [15:0] c, input bit b);
    bit fb;
    fb = c[15] ^ b;
    crc_msb = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
  endfunction

  task automatic close_frame();
    int n;
    logic [15:0] c;
    n = cur.size();
    if (n % 8 != 0 || n < 24) begin
      rx_lens.push_back(-1);
      rx_crcok.push_back(1'b0);
      return;
    end
    c = 16'hFFFF;
    foreach (cur[i]) c = crc_msb(c, cur[i]);
    rx_crcok.push_back(c == 16'h1D0F);
    rx_lens.push_back(n / 8 - 2);
    for (int k = 0; k < n / 8 - 2; k++) begin
      logic [7:0] v;
      for (int j = 0; j < 8; j++) v[j] = cur[8*k + j];
      rx_bytes.push_back(v);
    end
  endtask

  task automatic feed(input bit b);
    if (b) begin
      d_ones++;
      if (d_ones == 7) begin abort_cnt++; d_in = 1'b0; cur.delete(); end
      else if (d_in) cur.push_back(1'b1);
    end else begin
      if (d_ones == 6) begin
        if (d_in && cur.size() >= 7) begin
          repeat (7) void'(cur.pop_back());
          if (cur.size() > 0) close_frame();
        end
        cur.delete();
        d_in = 1'b1;
      end else if (d_ones == 5) begin
        if (d_in) stuff_cnt++;
      end else if (d_in) cur.push_back(1'b0);
      d_ones = 0;
    end
  endtask

  task automatic step(input bit g);
    gate = g;
    @(negedge clk);
    if (g) begin sq.push_back(tx_bit); feed(tx_bit); end
    else if (tx_bit !== last_tx) hold_err++;
    last_tx = tx_bit;
  endtask

  task automatic run_bits(input int n, input int dens);
    int got = 0;
    while (got < n) begin
      bit g;
      g = (($urandom % 100) < dens);
      step(g);
      if (g) got++;
    end
  endtask

  // mode 0 random, 1 all 0xFF, 2 all 0x7E
  task automatic send_msg(input int len, input int mode, input bit eom, input bit expect_it);
    logic [7:0] m[$];
    for (int i = 0; i < len; i++) begin
      logic [7:0] v;
      v = (mode == 1) ? 8'hFF : (mode == 2) ? 8'h7E : 8'($urandom);
      gate = 1'b0; wr_valid = 1'b1; wr_byte = v; wr_eom = eom && (i == len - 1);
      @(negedge clk);
      m.push_back(v);
    end
    wr_valid = 1'b0; wr_eom = 1'b0;
    if (eom && expect_it) begin
      foreach (m[i]) exp_bytes.push_back(m[i]);
      exp_lens.push_back(len);
    end
  endtask

  task automatic check_frames(input string req);
    check(rx_lens.size() == exp_lens.size(), req, "frame count", rx_lens.size(), exp_lens.size());
    while (rx_lens.size() > 0 && exp_lens.size() > 0) begin
      int rl, el, mism;
      bit ok;
      rl = rx_lens.pop_front(); el = exp_lens.pop_front(); ok = rx_crcok.pop_front();
      check(rl == el, req, "frame length", rl, el);
      check(ok, "R6", "check sequence residue", 0, 1);
      mism = 0;
      for (int i = 0; i < el; i++) begin
        logic [7:0] e, r;
        e = exp_bytes.pop_front();
        r = (i < rl) ? rx_bytes.pop_front() : 8'h00;
        if (e !== r) mism++;
      end
      for (int i = el; i < rl; i++) void'(rx_bytes.pop_front());
      check(mism == 0, req, "payload byte mismatches", mism, 0);
    end
    rx_lens.delete(); rx_bytes.delete(); rx_crcok.delete();
    exp_lens.delete(); exp_bytes.delete();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog R1..all actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int a0, s0, bad;
    logic v;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_valid = 1'b0; wr_eom = 1'b0; wr_byte = 8'h00; gate = 1'b0; abort_req = 1'b0;
    repeat (3) @(negedge clk);
    check(tx_bit === 1'b1 && underrun === 1'b0 && buf_ready === 1'b1, "R1", "outputs in reset", {tx_bit, underrun, buf_ready}, 3'b101);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_bit === 1'b1 && underrun === 1'b0 && buf_ready === 1'b1, "R1", "outputs after reset", {tx_bit, underrun, buf_ready}, 3'b101);

    // R2: idle flags, first bits form a flag (R1)
    run_bits(24, 100);
    check(sq[0] == 1'b0 && sq[1] == 1'b1, "R1", "first gated bits", {sq[0], sq[1]}, 1);
    bad = 0;
    for (int i = 0; i < 24; i++) if (sq[i] != ((8'h7E >> (i % 8)) & 8'h01)) bad++;
    check(bad == 0, "R2", "idle flag bit errors", bad, 0);

    // R3: hold with gate low
    v = tx_bit;
    repeat (6) step(1'b0);
    check(tx_bit === v, "R3", "tx_bit held while ungated", tx_bit, v);

    // R4: random messages
    for (int k = 0; k < 4; k++) begin
      int len;
      len = 1 + int'($urandom % 20);
      send_msg(len, 0, 1'b1, 1'b1);
      run_bits(len * 10 + 60, 60);
      check_frames("R4");
    end

    // R5: stuffing-heavy payloads
    s0 = stuff_cnt;
    send_msg(8, 1, 1'b1, 1'b1);
    run_bits(200, 50);
    check_frames("R5");
    check(stuff_cnt - s0 >= 12, "R5", "inserted zeros for all-ones payload", stuff_cnt - s0, 12);
    send_msg(6, 2, 1'b1, 1'b1);
    run_bits(150, 70);
    check_frames("R5");

    // R6: single-byte frame
    send_msg(1, 0, 1'b1, 1'b1);
    run_bits(80, 40);
    check_frames("R6");

    // R10: two messages queued together
    send_msg(5, 0, 1'b1, 1'b1);
    send_msg(9, 0, 1'b1, 1'b1);
    run_bits(300, 60);
    check_frames("R10");

    // R7: full buffer, extra write ignored
    send_msg(64, 0, 1'b1, 1'b1);
    check(buf_ready === 1'b0, "R7", "buf_ready with 64 stored", buf_ready, 0);
    send_msg(1, 0, 1'b1, 1'b0);
    run_bits(64 * 10 + 80, 80);
    check_frames("R7");
    check(buf_ready === 1'b1, "R7", "buf_ready after drain", buf_ready, 1);

    // R8: abort mid-frame
    a0 = abort_cnt;
    send_msg(30, 0, 1'b1, 1'b0);
    run_bits(100, 60);
    abort_req = 1'b1;
    step(1'b0);
    abort_req = 1'b0;
    run_bits(60, 60);
    check(abort_cnt == a0 + 1, "R8", "abort sequences seen", abort_cnt - a0, 1);
    check(rx_lens.size() == 0, "R8", "frames decoded from aborted message", rx_lens.size(), 0);
    check(buf_ready === 1'b1, "R8", "buf_ready after abort", buf_ready, 1);
    send_msg(5, 0, 1'b1, 1'b1);
    run_bits(120, 60);
    check_frames("R8");

    // R9: underrun
    a0 = abort_cnt;
    send_msg(5, 0, 1'b0, 1'b0);
    run_bits(100, 60);
    check(underrun === 1'b1, "R9", "underrun flag set", underrun, 1);
    check(abort_cnt == a0 + 1, "R9", "abort after underrun", abort_cnt - a0, 1);
    check(rx_lens.size() == 0, "R9", "frames decoded from underrun", rx_lens.size(), 0);
    send_msg(4, 0, 1'b1, 1'b1);
    run_bits(12, 60);
    check(underrun === 1'b0, "R9", "underrun cleared at frame start", underrun, 0);
    run_bits(100, 60);
    check_frames("R9");

    check(hold_err == 0, "R3", "ungated cycles with tx_bit change", hold_err, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule